// File: doc/BRIEF.md
# Piecewise-Parabolic Fractional-Delay Interpolator

This block produces one interpolated sample from a window of four consecutive signed input samples and an unsigned fractional interval `mu`. The four samples are, oldest first, x(n-2), x(n-1), x(n) and x(n+1). The result is a weighted sum of the four samples. The weights are second-order polynomials in `mu`, taken from the piecewise-parabolic family with the free design parameter equal to one half. It is meant to sit behind a timing-recovery loop that picks the sample window and the fractional interval. The loop presents one window per cycle, and the block returns the interpolant a fixed number of cycles later.

The computation follows a Farrow arrangement with three branches. The squared branch and the linear branch are formed from the samples using only halving shifts, additions and subtractions. The one-and-a-half weight on x(n-1) is built as a half plus a whole. The constant branch is x(n) itself. The three branches are then combined by two nested multiply-add steps in `mu`. These two steps are the only multipliers in the block. The branch values and both Horner steps are kept exact. The result is rounded and clamped back to the input width only at the end.

Top module: `pfi_interp`

## Requirements
- R1: The output `out_valid` is `in_valid` delayed by exactly three clock cycles. A new window is accepted every cycle, and idle cycles in the input stream reappear as idle cycles at the output.
- R2: When `in_mu` is 0, `out_sample` equals the x(n) input (`in_x0`) of the same window exactly.
- R3: Let u = `in_mu`/2^MUW. The output is the exact value w2·x(n-2) + w1·x(n-1) + w0·x(n) + w3·x(n+1), where w2 = u²/2 − u/2, w1 = −u²/2 + 3u/2, w0 = 1 − u/2 − u²/2 and w3 = u²/2 − u/2. This value is rounded to the nearest integer, and ties round toward positive infinity.
- R4: A rounded result above 2^(DW-1)−1 (127 by default) is output as 2^(DW-1)−1.
- R5: A rounded result below −2^(DW-1) (−128 by default) is output as −2^(DW-1).
- R6: While `rst` is high at a clock edge, `out_valid` and `out_sample` are cleared to 0 after that edge, whatever `in_valid` carries.
- R7: When all four samples of a window are equal, the output equals that sample for every value of `in_mu`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The window and `in_mu` on this cycle are to be processed |
| in_mu | input | MUW | Unsigned fractional interval, value `in_mu`/2^MUW in [0,1) |
| in_xm2 | input | DW | Signed sample x(n-2) |
| in_xm1 | input | DW | Signed sample x(n-1) |
| in_x0 | input | DW | Signed sample x(n), the constant branch |
| in_xp1 | input | DW | Signed sample x(n+1) |
| out_valid | output | 1 | `out_sample` holds a result |
| out_sample | output | DW | Signed rounded and clamped interpolant |

## Verification
The block is tried with several kinds of input window. Windows with `in_mu` at zero show whether the constant branch passes through untouched. Flat windows with random `in_mu` show that the four weights sum to exactly one. Windows with a single non-zero sample at half-way `in_mu` land on exact ties of +2.5 and −2.5, which separates round-half-up from truncation and from rounding away from zero. Extreme windows push the result past both ends of the output range to exercise the clamps. Long random streams with idle gaps, including `in_mu` of 1 and 255, are compared against an exact integer model, which exposes errors in the branch sums, the Horner alignment and the valid timing.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

    // Number of register stages from input window to output sample.
    localparam int unsigned PIPE_DEPTH = 3;

    // Round a fixed-point value with `sh` fraction bits to the nearest integer
    // (ties toward +inf), then clamp it to a signed range of `dw` bits.
    function automatic logic signed [63:0] round_clamp(
        input logic signed [63:0] v,
        input int unsigned        sh,
        input int unsigned        dw
    );
        logic signed [63:0] r;
        logic signed [63:0] top;
        logic signed [63:0] bot;
        r   = (v + (64'sd1 <<< (sh - 1))) >>> sh;
        top = (64'sd1 <<< (dw - 1)) - 64'sd1;
        bot = -(64'sd1 <<< (dw - 1));
        if (r > top) begin
            r = top;
        end else if (r < bot) begin
            r = bot;
        end
        return r;
    endfunction

endpackage

// File: rtl/pfi_branch_sum.sv
// Squared and linear Farrow branches, each carried with one fraction bit so
// that every halving weight is exact. Only shifts and adds are used.
module pfi_branch_sum #(
    parameter int DW = 8,
    parameter int BW = DW + 3
) (
    input  logic signed [DW-1:0] xm2,
    input  logic signed [DW-1:0] xm1,
    input  logic signed [DW-1:0] x0,
    input  logic signed [DW-1:0] xp1,
    output logic signed [BW-1:0] sq_br,
    output logic signed [BW-1:0] lin_br
);

    // A sample weighted by 1/2: same bits, read with one fraction bit.
    function automatic logic signed [BW-1:0] halfw(input logic signed [DW-1:0] s);
        return BW'(s);
    endfunction

    // A sample weighted by 1: moved up past the fraction bit.
    function automatic logic signed [BW-1:0] wholew(input logic signed [DW-1:0] s);
        return BW'(s) <<< 1;
    endfunction

    logic signed [BW-1:0] xm1_3h;

    always_comb begin
        // 3/2 weight made as 1/2 + 1
        xm1_3h = halfw(xm1) + wholew(xm1);
        sq_br  = halfw(xm2) - halfw(xm1) - halfw(x0) + halfw(xp1);
        lin_br = xm1_3h - halfw(xm2) - halfw(x0) - halfw(xp1);
    end

endmodule

// File: rtl/pfi_horner_step.sv
// One nested step: res = acc * mu + (addend << CSH), exact in OW bits.
module pfi_horner_step #(
    parameter int AW  = 11,
    parameter int MUW = 8,
    parameter int CW  = 11,
    parameter int CSH = 8,
    parameter int OW  = 21
) (
    input  logic signed [AW-1:0]  acc,
    input  logic        [MUW-1:0] mu,
    input  logic signed [CW-1:0]  addend,
    output logic signed [OW-1:0]  res
);

    logic signed [MUW:0]  mu_s;
    logic signed [OW-1:0] prod;
    logic signed [OW-1:0] add_al;

    always_comb begin
        mu_s   = $signed({1'b0, mu});
        prod   = OW'(acc) * OW'(mu_s);
        add_al = OW'(addend) <<< CSH;
        res    = prod + add_al;
    end

endmodule

// File: rtl/pfi_round_sat.sv
// Drop SH fraction bits with round-half-up, clamp to DW signed bits.
module pfi_round_sat #(
    parameter int IW = 31,
    parameter int SH = 17,
    parameter int DW = 8
) (
    input  logic signed [IW-1:0] v,
    output logic signed [DW-1:0] y
);

    logic signed [63:0] wide;

    always_comb begin
        wide = pfi_pkg::round_clamp(64'(v), SH, DW);
        y    = wide[DW-1:0];
    end

endmodule

// File: rtl/pfi_interp.sv
module pfi_interp #(
    parameter int DW  = 8,
    parameter int MUW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic        [MUW-1:0] in_mu,
    input  logic signed [DW-1:0]  in_xm2,
    input  logic signed [DW-1:0]  in_xm1,
    input  logic signed [DW-1:0]  in_x0,
    input  logic signed [DW-1:0]  in_xp1,
    output logic                  out_valid,
    output logic signed [DW-1:0]  out_sample
);

    // Branch width: sample, growth of the 3x / 4x sums, one fraction bit.
    localparam int BW  = DW + 3;
    // First Horner result: BW * (MUW+1 signed) plus the aligned addend.
    localparam int TW  = BW + MUW + 2;
    // Second Horner result, 2*MUW+1 fraction bits.
    localparam int PW  = TW + MUW + 2;
    localparam int RSH = 2 * MUW + 1;

    typedef struct packed {
        logic                  vld;
        logic        [MUW-1:0] mu;
        logic signed [DW-1:0]  base;
        logic signed [BW-1:0]  sq;
        logic signed [BW-1:0]  lin;
    } brs_t;

    typedef struct packed {
        logic                  vld;
        logic        [MUW-1:0] mu;
        logic signed [DW-1:0]  base;
        logic signed [TW-1:0]  acc;
    } hrn_t;

    brs_t st1;
    hrn_t st2;

    logic signed [BW-1:0] sq_c;
    logic signed [BW-1:0] lin_c;
    logic signed [TW-1:0] acc1_c;
    logic signed [PW-1:0] acc2_c;
    logic signed [DW-1:0] y_c;

    // Stage 1: shift-add branch sums
    pfi_branch_sum #(.DW(DW), .BW(BW)) u_branch (
        .xm2   (in_xm2),
        .xm1   (in_xm1),
        .x0    (in_x0),
        .xp1   (in_xp1),
        .sq_br (sq_c),
        .lin_br(lin_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
        end else begin
            st1.vld  <= in_valid;
            st1.mu   <= in_mu;
            st1.base <= in_x0;
            st1.sq   <= sq_c;
            st1.lin  <= lin_c;
        end
    end

    // Stage 2: sq * mu + lin, aligned to 1 + MUW fraction bits
    pfi_horner_step #(
        .AW(BW), .MUW(MUW), .CW(BW), .CSH(MUW), .OW(TW)
    ) u_step_a (
        .acc   (st1.sq),
        .mu    (st1.mu),
        .addend(st1.lin),
        .res   (acc1_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st2 <= '0;
        end else begin
            st2.vld  <= st1.vld;
            st2.mu   <= st1.mu;
            st2.base <= st1.base;
            st2.acc  <= acc1_c;
        end
    end

    // Stage 3: acc * mu + base, aligned to 1 + 2*MUW fraction bits
    pfi_horner_step #(
        .AW(TW), .MUW(MUW), .CW(DW), .CSH(RSH), .OW(PW)
    ) u_step_b (
        .acc   (st2.acc),
        .mu    (st2.mu),
        .addend(st2.base),
        .res   (acc2_c)
    );

    pfi_round_sat #(.IW(PW), .SH(RSH), .DW(DW)) u_round (
        .v(acc2_c),
        .y(y_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid  <= st2.vld;
            out_sample <= y_c;
        end
    end

endmodule

// File: rtl/pfi_interp_chk.sv
module pfi_interp_chk #(
    parameter int DW  = 8,
    parameter int MUW = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic        [MUW-1:0] in_mu,
    input logic signed [DW-1:0]  in_xm2,
    input logic signed [DW-1:0]  in_xm1,
    input logic signed [DW-1:0]  in_x0,
    input logic signed [DW-1:0]  in_xp1,
    input logic                  out_valid,
    input logic signed [DW-1:0]  out_sample
);

    // Cycles since reset release, saturating at the pipeline depth.
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: valid emerges exactly three cycles after it enters
    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2: zero interval passes x(n) through unchanged
    assert_mu_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(in_valid, 3) && $past(in_mu, 3) == '0)
        |-> (out_sample == $past(in_x0, 3)));

    // R7: a flat window reproduces its level
    assert_flat_window_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(in_valid, 3)
         && $past(in_xm2, 3) == $past(in_x0, 3)
         && $past(in_xm1, 3) == $past(in_x0, 3)
         && $past(in_xp1, 3) == $past(in_x0, 3))
        |-> (out_sample == $past(in_x0, 3)));

    // R6: reset clears the outputs on the following cycle
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

endmodule

bind pfi_interp pfi_interp_chk #(.DW(DW), .MUW(MUW)) u_chk (.*);

// File: tb/pfi_interp_bench.sv
`timescale 1ns/1ps
module pfi_interp_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic        [7:0] in_mu = '0;
    logic signed [7:0] in_xm2 = '0;
    logic signed [7:0] in_xm1 = '0;
    logic signed [7:0] in_x0  = '0;
    logic signed [7:0] in_xp1 = '0;
    logic              out_valid;
    logic signed [7:0] out_sample;

    always #2.5 clk = ~clk;

    pfi_interp u_pfi_interp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mu(in_mu),
        .in_xm2(in_xm2), .in_xm1(in_xm1), .in_x0(in_x0), .in_xp1(in_xp1),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    typedef struct {
        logic signed [7:0] y;
        longint            due;
        string             req;
    } exp_t;

    exp_t   sb[$];
    longint cyc = 0;
    int     n_chk = 0;
    int     n_bad = 0;
    bit     mon_on = 1'b0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Exact model of the weighted sum, scaled by 2^17, then round and clamp.
    function automatic logic signed [7:0] model(
        input logic signed [7:0] a, input logic signed [7:0] b,
        input logic signed [7:0] c, input logic signed [7:0] d,
        input logic [7:0] m);
        longint s2, s1, big, r, mm;
        mm  = longint'(m);
        s2  = longint'(a) - longint'(b) - longint'(c) + longint'(d);
        s1  = 3 * longint'(b) - longint'(a) - longint'(c) - longint'(d);
        big = s2 * mm * mm + s1 * mm * 256 + longint'(c) * 131072;
        r   = (big + 65536) >>> 17;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return 8'(r);
    endfunction

    task automatic check(input string req, input longint act, input longint exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Driver: one window per call, expected result queued.
    task automatic put(input logic signed [7:0] a, input logic signed [7:0] b,
                       input logic signed [7:0] c, input logic signed [7:0] d,
                       input logic [7:0] m, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_xm2 = a; in_xm1 = b; in_x0 = c; in_xp1 = d; in_mu = m;
        e.y = model(a, b, c, d, m);
        e.due = cyc + 3;
        e.req = req;
        sb.push_back(e);
    endtask

    // Idle cycles carry junk data that must not produce output.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_xm2 = 8'($urandom); in_xm1 = 8'($urandom);
            in_x0 = 8'($urandom); in_xp1 = 8'($urandom); in_mu = 8'($urandom);
        end
    endtask

    // Monitor: pop and compare whenever a result appears.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R1 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R1 latency cycle", cyc, e.due);
                    check(e.req, out_sample, e.y);
                end
            end else if (sb.size() > 0 && sb[0].due == cyc) begin
                check("R1 missing out_valid", 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        // R6: reset dominates a valid input
        in_valid = 1'b1; in_x0 = 8'sd55; in_mu = 8'd0;
        repeat (4) @(negedge clk);
        check("R6 out_valid in reset", out_valid, 0);
        check("R6 out_sample in reset", out_sample, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        mon_on = 1'b1;
        idle(4);

        // R3 hand values: 40, and ties +2.5 -> 3, -2.5 -> -2
        put(8'sd0, 8'sd64, 8'sd0, 8'sd0, 8'd128, "R3 hand value");
        put(8'sd0, 8'sd4, 8'sd0, 8'sd0, 8'd128, "R3 tie positive");
        put(8'sd0, -8'sd4, 8'sd0, 8'sd0, 8'd128, "R3 tie negative");
        sb[sb.size()-3].y = 8'sd40;
        sb[sb.size()-2].y = 8'sd3;
        sb[sb.size()-1].y = -8'sd2;

        // R2: zero interval
        for (int i = 0; i < 24; i++) begin
            logic signed [7:0] c;
            c = 8'($urandom);
            put(8'($urandom), 8'($urandom), c, 8'($urandom), 8'd0, "R2 mu zero");
            sb[sb.size()-1].y = c;
        end
        idle(2);

        // R7: flat windows, including both extremes
        for (int i = 0; i < 24; i++) begin
            logic signed [7:0] c;
            c = (i == 0) ? -8'sd128 : (i == 1) ? 8'sd127 : 8'($urandom);
            put(c, c, c, c, (i < 2) ? 8'd255 : 8'($urandom), "R7 flat window");
            sb[sb.size()-1].y = c;
        end

        // R4 / R5: clamps
        put(-8'sd128, 8'sd127, 8'sd127, -8'sd128, 8'd128, "R4 clamp high");
        sb[sb.size()-1].y = 8'sd127;
        put(8'sd127, -8'sd128, -8'sd128, 8'sd127, 8'd128, "R5 clamp low");
        sb[sb.size()-1].y = -8'sd128;
        idle(3);

        // R3 boundary intervals and R1 bubbles in a random stream
        for (int i = 0; i < 400; i++) begin
            logic [7:0] m;
            m = (i % 7 == 0) ? 8'd255 : (i % 7 == 1) ? 8'd1 : 8'($urandom);
            put(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), m, "R3 random");
            if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
        end
        idle(6);
        check("R1 queue drained", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule